// File: doc/BRIEF.md
# Secured Configuration Store

This block holds the configuration image of a programmable logic fabric: a word-addressed array of connection and cell-setting bits, plus a separate signature word that names the loaded pattern. A host drives one command per cycle over a valid/ready interface: read a word, program a word, program a word and lock in one step, lock, wipe everything, write the signature, or read the signature. Every command gets one response carrying an error flag and read data.

Once the lock is set, the array can be neither read nor programmed. The only way out is a full wipe, which clears the array, the signature and the lock together. The signature is the one item that stays readable while the array is locked.

Each word may be programmed only once between two wipes, so a new image always starts from a wiped array. A wipe walks the array one address per cycle and reports busy while it runs. Reset starts the same walk, so the block always comes out of reset blank, unlocked and with no trace of an earlier image.

Top module: `cfg_lock_store`

## Requirements
- R1: `cmd_ready` is high exactly when `busy` is low. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Every taken command other than a wipe gives `rsp_valid` high for one cycle, in the cycle after the command is taken. `rsp_rdata` is zero in every response except an allowed read.
- R2: Reset (`rst` high, synchronous) makes `busy` and `locked` high. After `rst` falls, `busy` stays high for 2**ADDR_W cycles. After that, every word reads zero, the signature reads zero, `locked` is low, and no response is given for this walk.
- R3: A read (`cmd_op` = 0) while unlocked returns the stored word at `cmd_addr`, zero-extended into `rsp_rdata`, with `rsp_err` = 0.
- R4: A program (`cmd_op` = 1) while unlocked stores `cmd_wdata[DATA_W-1:0]` at `cmd_addr`, with `rsp_err` = 0, if that word has not been programmed since the last wipe. Otherwise it is refused with `rsp_err` = 1 and the word keeps its value.
- R5: A lock command (`cmd_op` = 3) sets `locked` and answers with `rsp_err` = 0. A program-and-lock (`cmd_op` = 2) follows the rules of R4 and, only if the program succeeds, sets `locked` as well. `locked` is high from the cycle after the command is taken.
- R6: While `locked` is high: a read answers `rsp_err` = 1 with `rsp_rdata` = 0; program, program-and-lock and signature writes are refused with `rsp_err` = 1 and change nothing; and `locked` stays high until a wipe completes.
- R7: A wipe (`cmd_op` = 4) raises `busy` in the cycle after it is taken and holds it for 2**ADDR_W cycles. In the cycle when `busy` falls, `rsp_valid` is high with `rsp_err` = 0. From that cycle on, all words and the signature are zero, `locked` is low, and every word and the signature can be programmed again.
- R8: A signature write (`cmd_op` = 5) while unlocked stores `cmd_wdata[SIG_W-1:0]` if the signature has not been written since the last wipe; otherwise it gets `rsp_err` = 1. A signature read (`cmd_op` = 6) returns the signature with `rsp_err` = 0, whether or not the block is locked.
- R9: Opcode 7 is reserved. It answers with `rsp_err` = 1 and `rsp_rdata` = 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts a wipe |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Opcode (0 read, 1 program, 2 program-and-lock, 3 lock, 4 wipe, 5 signature write, 6 signature read, 7 reserved) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | max(DATA_W,SIG_W) | Program or signature data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Command refused or reserved |
| rsp_rdata | output | max(DATA_W,SIG_W) | Read data, zero when not allowed |
| busy | output | 1 | Wipe in progress |
| locked | output | 1 | Security lock state |

## Verification
A taken command answers in the very next cycle. A wipe answers 2**ADDR_W + 1 cycles after it is taken, in the same cycle where `busy` falls and `cmd_ready` rises. Lock and unlock show on `locked` one cycle after the command that caused them, or in the cycle the wipe ends. The bench runs a behavioural model that advances on each rising edge and compares ready, busy, lock and every response field on each falling edge, so each result is checked in exactly the cycle it is due. Commands held during a wipe are checked for being taken only once `cmd_ready` returns.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_PROG      = 3'd1,
    OP_PROG_LOCK = 3'd2,
    OP_LOCK      = 3'd3,
    OP_WIPE      = 3'd4,
    OP_SIG_WR    = 3'd5,
    OP_SIG_RD    = 3'd6,
    OP_RSVD      = 3'd7
  } opcode_t;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_MEM  = 2'd1,
    SEL_SIG  = 2'd2
  } rsel_t;
endpackage

// File: rtl/cfgs_erase_seq.sv
module cfgs_erase_seq #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              by_cmd
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic              busy_q;
  logic [ADDR_W-1:0] cnt_q;
  logic              by_cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b1;
      cnt_q    <= '0;
      by_cmd_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end else if (start) begin
      busy_q   <= 1'b1;
      cnt_q    <= '0;
      by_cmd_q <= 1'b1;
    end
  end

  assign busy   = busy_q;
  assign addr   = cnt_q;
  assign done   = busy_q && (cnt_q == LAST);
  assign by_cmd = by_cmd_q;
endmodule

// File: rtl/cfgs_cmd_dec.sv
module cfgs_cmd_dec
  import cfgs_pkg::*;
(
  input  logic    fire,
  input  opcode_t op,
  input  logic    locked,
  input  logic    word_used,
  input  logic    sig_used,
  output logic    prog_we,
  output logic    lock_set,
  output logic    sig_we,
  output logic    wipe_go,
  output logic    rsp_go,
  output logic    err,
  output rsel_t   sel
);
  logic prog_ok;
  logic sig_ok;

  assign prog_ok = !locked && !word_used;
  assign sig_ok  = !locked && !sig_used;

  always_comb begin
    prog_we  = 1'b0;
    lock_set = 1'b0;
    sig_we   = 1'b0;
    wipe_go  = 1'b0;
    rsp_go   = fire;
    err      = 1'b0;
    sel      = SEL_ZERO;
    if (fire) begin
      unique case (op)
        OP_READ: begin
          err = locked;
          sel = locked ? SEL_ZERO : SEL_MEM;
        end
        OP_PROG: begin
          prog_we = prog_ok;
          err     = !prog_ok;
        end
        OP_PROG_LOCK: begin
          prog_we  = prog_ok;
          lock_set = prog_ok;
          err      = !prog_ok;
        end
        OP_LOCK:   lock_set = 1'b1;
        OP_WIPE: begin
          wipe_go = 1'b1;
          rsp_go  = 1'b0;
        end
        OP_SIG_WR: begin
          sig_we = sig_ok;
          err    = !sig_ok;
        end
        OP_SIG_RD: sel = SEL_SIG;
        default:   err = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cfgs_mem.sv
module cfgs_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store
  import cfgs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int SIG_W  = 24
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          cmd_valid,
  output logic                                          cmd_ready,
  input  logic [2:0]                                    cmd_op,
  input  logic [ADDR_W-1:0]                             cmd_addr,
  input  logic [((DATA_W > SIG_W) ? DATA_W : SIG_W)-1:0] cmd_wdata,
  output logic                                          rsp_valid,
  output logic                                          rsp_err,
  output logic [((DATA_W > SIG_W) ? DATA_W : SIG_W)-1:0] rsp_rdata,
  output logic                                          busy,
  output logic                                          locked
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int RD_W  = (DATA_W > SIG_W) ? DATA_W : SIG_W;

  logic              fire;
  logic              prog_we, lock_set, sig_we, wipe_go, rsp_go, err_d;
  rsel_t             sel_d, sel_q;
  logic              done, by_cmd;
  logic [ADDR_W-1:0] wipe_addr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] rd_q;
  logic [DEPTH-1:0]  used_q;
  logic [SIG_W-1:0]  sig_q;
  logic              sig_used_q;
  logic              lock_q;
  logic              rv_q, err_q;

  assign fire      = cmd_valid && !busy;
  assign cmd_ready = !busy;

  cfgs_erase_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (wipe_go),
    .busy   (busy),
    .addr   (wipe_addr),
    .done   (done),
    .by_cmd (by_cmd)
  );

  cfgs_cmd_dec u_dec (
    .fire      (fire),
    .op        (opcode_t'(cmd_op)),
    .locked    (lock_q),
    .word_used (used_q[cmd_addr]),
    .sig_used  (sig_used_q),
    .prog_we   (prog_we),
    .lock_set  (lock_set),
    .sig_we    (sig_we),
    .wipe_go   (wipe_go),
    .rsp_go    (rsp_go),
    .err       (err_d),
    .sel       (sel_d)
  );

  assign mem_we    = busy || prog_we;
  assign mem_waddr = busy ? wipe_addr : cmd_addr;
  assign mem_wdata = busy ? '0 : cmd_wdata[DATA_W-1:0];

  cfgs_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (cmd_addr),
    .rdata (rd_q)
  );

  // programmed-since-wipe marks, one per word
  always_ff @(posedge clk) begin
    if (done)         used_q <= '0;
    else if (prog_we) used_q[cmd_addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (done) begin
      sig_q      <= '0;
      sig_used_q <= 1'b0;
    end else if (sig_we) begin
      sig_q      <= cmd_wdata[SIG_W-1:0];
      sig_used_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           lock_q <= 1'b1;
    else if (done)     lock_q <= 1'b0;
    else if (lock_set) lock_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rv_q  <= 1'b0;
      err_q <= 1'b0;
      sel_q <= SEL_ZERO;
    end else begin
      rv_q  <= rsp_go || (done && by_cmd);
      err_q <= rsp_go && err_d;
      sel_q <= rsp_go ? sel_d : SEL_ZERO;
    end
  end

  always_comb begin
    unique case (sel_q)
      SEL_MEM: rsp_rdata = RD_W'(rd_q);
      SEL_SIG: rsp_rdata = RD_W'(sig_q);
      default: rsp_rdata = '0;
    endcase
  end

  assign rsp_valid = rv_q;
  assign rsp_err   = err_q;
  assign locked    = lock_q;
endmodule

// File: rtl/cfgs_chk.sv
module cfgs_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int SIG_W  = 24
) (
  input logic                                          clk,
  input logic                                          rst,
  input logic                                          cmd_valid,
  input logic                                          cmd_ready,
  input logic [2:0]                                    cmd_op,
  input logic                                          busy,
  input logic                                          locked,
  input logic                                          rsp_valid,
  input logic                                          rsp_err,
  input logic [((DATA_W > SIG_W) ? DATA_W : SIG_W)-1:0] rsp_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W+1:0] run_q;
  logic              take;

  assign take = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
    (take && cmd_op != 3'd4) |=> rsp_valid); // R1
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !rsp_valid); // R1
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (busy && locked && !rsp_valid)); // R2
  AST_LOCKED_READ_BLANK: assert property (@(posedge clk) disable iff (rst)
    (take && cmd_op == 3'd0 && locked) |=> (rsp_valid && rsp_err && rsp_rdata == '0)); // R6
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (locked && !busy) |=> locked); // R6
  AST_WIPE_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_q == (ADDR_W+2)'(DEPTH) && !locked)); // R7
  AST_SIG_READ_OPEN: assert property (@(posedge clk) disable iff (rst)
    (take && cmd_op == 3'd6) |=> (rsp_valid && !rsp_err)); // R8
  AST_RSVD_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (take && cmd_op == 3'd7) |=> (rsp_err && rsp_rdata == '0)); // R9
endmodule

bind cfg_lock_store cfgs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_W(SIG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .locked    (locked),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata)
);

// File: tb/sim_cfg_lock_store.sv
`timescale 1ns/1ps
module sim_cfg_lock_store;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int SIG_W  = 24;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int RD_W   = 24;

  localparam logic [2:0] RD = 3'd0, PG = 3'd1, PGL = 3'd2, LK = 3'd3,
                         WP = 3'd4, SW = 3'd5, SR = 3'd6, RS = 3'd7;

  logic              clk = 1'b0;
  logic              rst;
  logic              cmd_valid;
  logic              cmd_ready;
  logic [2:0]        cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [RD_W-1:0]   cmd_wdata;
  logic              rsp_valid, rsp_err, busy, locked;
  logic [RD_W-1:0]   rsp_rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cfg_lock_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_W(SIG_W)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .busy(busy), .locked(locked)
  );

  // behavioural reference model
  logic [DATA_W-1:0] m_mem [DEPTH];
  bit                m_used [DEPTH];
  logic [SIG_W-1:0]  m_sig;
  bit                m_sigu;
  bit                m_busy, m_lock, m_rv, m_err, m_bycmd, started;
  int                m_cnt;
  logic [RD_W-1:0]   m_data;
  string             m_tag;

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      m_busy = 1; m_cnt = 0; m_lock = 1; m_rv = 0; m_bycmd = 0;
    end else begin
      m_rv = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == DEPTH) begin
          m_busy = 0; m_cnt = 0;
          for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_used[i] = 0; end
          m_lock = 0; m_sig = '0; m_sigu = 0;
          if (m_bycmd) begin m_rv = 1; m_err = 0; m_data = '0; m_tag = "R7"; end
        end
      end else if (cmd_valid) begin
        m_rv = 1; m_err = 0; m_data = '0;
        case (cmd_op)
          RD: begin
            if (m_lock) begin m_err = 1; m_tag = "R6"; end
            else begin m_data = RD_W'(m_mem[cmd_addr]); m_tag = "R3"; end
          end
          PG, PGL: begin
            m_tag = (cmd_op == PG) ? "R4" : "R5";
            if (m_lock) begin m_err = 1; m_tag = "R6"; end
            else if (m_used[cmd_addr]) m_err = 1;
            else begin
              m_mem[cmd_addr] = cmd_wdata[DATA_W-1:0];
              m_used[cmd_addr] = 1;
              if (cmd_op == PGL) m_lock = 1;
            end
          end
          LK: begin m_lock = 1; m_tag = "R5"; end
          WP: begin m_rv = 0; m_busy = 1; m_cnt = 0; m_bycmd = 1; end
          SW: begin
            m_tag = "R8";
            if (m_lock || m_sigu) m_err = 1;
            else begin m_sig = cmd_wdata[SIG_W-1:0]; m_sigu = 1; end
          end
          SR: begin m_data = RD_W'(m_sig); m_tag = "R8"; end
          default: begin m_err = 1; m_tag = "R9"; end
        endcase
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(32'(cmd_ready), 32'(!m_busy), "R1 cmd_ready");
      chk(32'(busy), 32'(m_busy), m_bycmd ? "R7 busy" : "R2 busy");
      chk(32'(locked), 32'(m_lock), "R6 locked");
      chk(32'(rsp_valid), 32'(m_rv), "R1 rsp_valid");
      if (m_rv) begin
        chk(32'(rsp_err), 32'(m_err), {m_tag, " rsp_err"});
        chk(32'(rsp_rdata), 32'(m_data), {m_tag, " rsp_rdata"});
      end
    end
  end

  task automatic issue(input logic [2:0] op, input int addr, input logic [RD_W-1:0] d);
    logic r;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr[ADDR_W-1:0]; cmd_wdata = d;
    do begin r = cmd_ready; @(negedge clk); end while (!r);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready();
    while (!cmd_ready) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cmd_valid = 0; cmd_op = RD; cmd_addr = '0; cmd_wdata = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    wait_ready();                              // R2 reset walk
    issue(RD, 5, 0);                           // R2 blank word
    issue(SR, 0, 0);                           // R2 blank signature
    issue(PG, 5, 24'h1234);                    // R4
    issue(PG, 10, 24'hBEEF);
    issue(RD, 5, 0);                           // R3
    issue(RD, 10, 0);
    issue(PG, 5, 24'h7777);                    // R4 refused
    issue(RD, 5, 0);
    issue(SW, 0, 24'hABCDEF);                  // R8
    issue(SW, 0, 24'h111111);                  // R8 refused
    issue(SR, 0, 0);
    issue(RS, 3, 24'hFFFFFF);                  // R9
    issue(RD, 3, 0);
    issue(LK, 0, 0);                           // R5
    issue(RD, 5, 0);                           // R6
    issue(PG, 20, 24'h4242);                   // R6
    issue(PGL, 21, 24'h4343);                  // R6
    issue(SW, 0, 24'h000001);                  // R6
    issue(SR, 0, 0);                           // R8 while locked
    issue(LK, 0, 0);
    repeat (4) @(negedge clk);                 // R6 lock holds
    issue(WP, 0, 0);                           // R7
    issue(RD, 5, 0);                           // held during wipe
    issue(RD, 20, 0);
    issue(SR, 0, 0);
    issue(PG, 5, 24'h5555);                    // R7 re-program
    issue(RD, 5, 0);
    issue(SW, 0, 24'h00C0DE);
    issue(SR, 0, 0);
    issue(PGL, 6, 24'h0F0F);                   // R5
    issue(RD, 6, 0);
    issue(WP, 0, 0);
    issue(PG, 6, 24'h1111);
    issue(PGL, 6, 24'h2222);                   // R5 refused, no lock
    issue(RD, 6, 0);
    for (int i = 0; i < 16; i++) issue(PG, 32 + i, 24'(i * 37 + 1));
    for (int i = 0; i < 16; i++) issue(RD, 32 + i, 0);
    issue(WP, 0, 0);
    wait_ready();
    for (int i = 0; i < 4; i++) issue(RD, 32 + i, 0);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule